// File: doc/BRIEF.md
# Reset-Time Serial EEPROM Configuration Loader

This block runs once after every reset and fills a few configuration-space fields from a serial EEPROM. It reads a control byte first. The bits of that byte decide three things: whether the capability-list status bit is withdrawn, whether the subsystem vendor identifier is fetched, and whether the subsystem identifier is fetched. Only the fields that are switched on cost any reads. A field that is switched off, or that cannot be read, stays at zero.

The block talks to a byte-read engine that carries out the actual serial protocol. It gives the engine a single-cycle request with an address, and the engine answers later with a done pulse, a data byte and a no-acknowledge flag. Each read that gets no acknowledge is repeated a bounded number of times. Until the whole sequence is over, the completion flag stays low and host-initiated EEPROM reads are kept away from the engine. After that, host reads pass straight through.

Top module: `ee_cfg_loader`

## Requirements
- R1: During reset and until the first read finishes, `svid_o` and `sid_o` read 0x0000, `cap_list_o` reads 1 and `load_done_o` reads 0. After reset is released, the first engine request addresses byte 0x00.
- R2: If the control byte is read with acknowledge and its bit 2 is 1, `cap_list_o` is 0 by the time `load_done_o` rises. Otherwise it stays 1. Once it is 0, it does not return to 1 before the next reset.
- R3: Control bit 0 set: `svid_o` is loaded with byte 0x01 as its low byte and byte 0x02 as its high byte. Control bit 0 clear: bytes 0x01 and 0x02 are never requested, and `svid_o` stays 0x0000.
- R4: Control bit 1 set: `sid_o` is loaded with byte 0x03 as its low byte and byte 0x04 as its high byte. Control bit 1 clear: bytes 0x03 and 0x04 are never requested, and `sid_o` stays 0x0000.
- R5: Control bits 7 to 3 have no effect on the result.
- R6: The loader issues requests one at a time, with non-decreasing addresses (control, then the vendor field, then the subsystem field). Each request lasts one cycle and is issued only while `eng_busy_i` is low.
- R7: A read that ends with `eng_nack_i` = 1 is repeated at the same address, at most 4 more times. If one of the repeats succeeds, the result is the same as a read that never failed.
- R8: After 5 attempts that all get no acknowledge, the loader gives up on that read and carries on:
  - For a field byte, the whole field becomes 0x0000, and its remaining bytes are not requested.
  - For the control byte, the byte counts as 0x00.
- R9: While `load_done_o` is 0, `host_req_i` never produces an engine request. While it is 1, `eng_req_o` follows `host_req_i` and `eng_addr_o` follows `host_addr_i` in the same cycle.
- R10: `load_done_o` rises once the sequence ends and holds until reset. From then on, `svid_o`, `sid_o` and `cap_list_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req_i | input | 1 | Host read request toward the EEPROM engine |
| host_addr_i | input | 8 | Host read byte address |
| eng_req_o | output | 1 | Single-cycle read request to the engine |
| eng_addr_o | output | 8 | Byte address of the request |
| eng_busy_i | input | 1 | Engine is carrying out a transfer |
| eng_done_i | input | 1 | One-cycle pulse marking the end of a transfer |
| eng_nack_i | input | 1 | Transfer ended without acknowledge (valid with done) |
| eng_data_i | input | 8 | Byte read (valid with done) |
| svid_o | output | 16 | Subsystem vendor identifier |
| sid_o | output | 16 | Subsystem identifier |
| cap_list_o | output | 1 | Capability-list status bit (status bit 20) |
| load_done_o | output | 1 | Loading sequence complete |

## Verification
Two things can meet in the same cycle: a host read request and a loader read, and likewise a host read request and the edge where loading completes. The bench holds `host_req_i` high with a marker address for the whole load, so the host request overlaps every loader request and the rising edge of `load_done_o`. The engine model counts every request it accepts while loading is in progress, and any request carrying the marker address is judged a leak. After the load, a host request raised alone must reach the engine port in the same cycle, and the loaded fields must not move.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  localparam int NUM_FIELDS = 2;
  localparam int FLD_SVID   = 0;
  localparam int FLD_SID    = 1;

  typedef enum logic [1:0] {
    LS_START,
    LS_ISSUE,
    LS_WAIT,
    LS_DONE
  } ld_state_e;
endpackage

// File: rtl/ldr_retry.sv
module ldr_retry #(
  parameter int MAX_RETRY = 4,
  localparam int CW = $clog2(MAX_RETRY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          spent_o
);
  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    cnt_n  = cnt_q;
    if (clr_i)      cnt_n = '0;
    else if (inc_i) cnt_n = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign cnt_o   = cnt_q;
  assign spent_o = (cnt_q == CW'(MAX_RETRY));
endmodule

// File: rtl/ldr_fields.sv
module ldr_fields
  import ldr_pkg::*;
#(
  parameter int FIELD_BYTES = 2,
  localparam int FW     = 8 * FIELD_BYTES,
  localparam int FSEL_W = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
  localparam int BSEL_W = (FIELD_BYTES > 1) ? $clog2(FIELD_BYTES) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_i,
  input  logic                             clr_i,
  input  logic [FSEL_W-1:0]                fsel_i,
  input  logic [BSEL_W-1:0]                bsel_i,
  input  logic [7:0]                       data_i,
  output logic [NUM_FIELDS-1:0][FW-1:0]    fields_o
);
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    logic [FW-1:0] val_q, val_n;
    logic          hit, val_en;

    always_comb begin
      hit    = (fsel_i == FSEL_W'(f));
      val_en = hit & (wr_i | clr_i);
      val_n  = val_q;
      if (clr_i) begin
        val_n = '0;
      end else begin
        for (int b = 0; b < FIELD_BYTES; b++) begin
          if (bsel_i == BSEL_W'(b)) val_n[8*b +: 8] = data_i;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      val_q <= '0;
      else if (val_en) val_q <= val_n;
    end

    assign fields_o[f] = val_q;
  end
endmodule

// File: rtl/ldr_seq.sv
module ldr_seq
  import ldr_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int FIELD_BYTES = 2,
  parameter int CTRL_ADDR   = 0,
  localparam int FSEL_W = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
  localparam int BSEL_W = (FIELD_BYTES > 1) ? $clog2(FIELD_BYTES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  eng_busy_i,
  input  logic                  eng_done_i,
  input  logic                  eng_nack_i,
  input  logic [NUM_FIELDS-1:0] ctrl_en_i,
  input  logic                  ctrl_cap_i,
  input  logic                  retry_spent_i,
  output logic                  retry_clr_o,
  output logic                  retry_inc_o,
  output logic                  ld_req_o,
  output logic [ADDR_W-1:0]     ld_addr_o,
  output logic                  fld_wr_o,
  output logic                  fld_clr_o,
  output logic [FSEL_W-1:0]     fsel_o,
  output logic [BSEL_W-1:0]     bsel_o,
  output logic                  cap_list_o,
  output logic                  load_done_o
);
  ld_state_e             state_q, state_n;
  logic                  ctrl_q, ctrl_n;
  logic [FSEL_W-1:0]     fld_q, fld_n;
  logic [BSEL_W-1:0]     byte_q, byte_n;
  logic [NUM_FIELDS-1:0] en_q, en_n;
  logic                  cap_q, cap_n;
  logic                  ok;
  logic [FSEL_W:0]       pick;

  // lowest enabled field at or above 'from'; MSB flags that one exists
  function automatic logic [FSEL_W:0] first_en(input logic [NUM_FIELDS-1:0] en,
                                               input int from);
    logic [FSEL_W:0] res;
    res = '0;
    for (int i = NUM_FIELDS - 1; i >= 0; i--) begin
      if (i >= from && en[i]) res = {1'b1, FSEL_W'(i)};
    end
    return res;
  endfunction

  always_comb begin
    state_n     = state_q;
    ctrl_n      = ctrl_q;
    fld_n       = fld_q;
    byte_n      = byte_q;
    en_n        = en_q;
    cap_n       = cap_q;
    ld_req_o    = 1'b0;
    retry_clr_o = 1'b0;
    retry_inc_o = 1'b0;
    fld_wr_o    = 1'b0;
    fld_clr_o   = 1'b0;
    ok          = ~eng_nack_i;
    pick        = '0;
    unique case (state_q)
      LS_START: begin
        ctrl_n  = 1'b1;
        state_n = LS_ISSUE;
      end
      LS_ISSUE: begin
        ld_req_o = ~eng_busy_i;
        if (!eng_busy_i) state_n = LS_WAIT;
      end
      LS_WAIT: begin
        if (eng_done_i) begin
          if (eng_nack_i && !retry_spent_i) begin
            retry_inc_o = 1'b1;
            state_n     = LS_ISSUE;
          end else begin
            retry_clr_o = 1'b1;
            if (ctrl_q) begin
              en_n = ok ? ctrl_en_i : '0;
              if (ok && ctrl_cap_i) cap_n = 1'b0;
              pick = first_en(en_n, 0);
            end else if (ok && byte_q != BSEL_W'(FIELD_BYTES - 1)) begin
              fld_wr_o = 1'b1;
              byte_n   = byte_q + BSEL_W'(1);
              state_n  = LS_ISSUE;
            end else begin
              fld_wr_o  = ok;
              fld_clr_o = ~ok;
              pick      = first_en(en_q, int'(fld_q) + 1);
            end
            if (ctrl_q || !ok || byte_q == BSEL_W'(FIELD_BYTES - 1)) begin
              if (pick[FSEL_W]) begin
                ctrl_n  = 1'b0;
                fld_n   = pick[FSEL_W-1:0];
                byte_n  = '0;
                state_n = LS_ISSUE;
              end else begin
                state_n = LS_DONE;
              end
            end
          end
        end
      end
      default: state_n = LS_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LS_START;
      ctrl_q  <= 1'b1;
      fld_q   <= '0;
      byte_q  <= '0;
      en_q    <= '0;
      cap_q   <= 1'b1;
    end else begin
      state_q <= state_n;
      ctrl_q  <= ctrl_n;
      fld_q   <= fld_n;
      byte_q  <= byte_n;
      en_q    <= en_n;
      cap_q   <= cap_n;
    end
  end

  assign ld_addr_o   = ctrl_q ? ADDR_W'(CTRL_ADDR)
                              : ADDR_W'(CTRL_ADDR + 1 + int'(fld_q) * FIELD_BYTES + int'(byte_q));
  assign fsel_o      = fld_q;
  assign bsel_o      = byte_q;
  assign cap_list_o  = cap_q;
  assign load_done_o = (state_q == LS_DONE);
endmodule

// File: rtl/ee_cfg_loader.sv
module ee_cfg_loader
  import ldr_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int FIELD_BYTES = 2,
  parameter int CTRL_ADDR   = 0,
  parameter int CAP_BIT     = 2,
  parameter int MAX_RETRY   = 4,
  localparam int FW     = 8 * FIELD_BYTES,
  localparam int RCW    = $clog2(MAX_RETRY + 1),
  localparam int FSEL_W = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
  localparam int BSEL_W = (FIELD_BYTES > 1) ? $clog2(FIELD_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  output logic              eng_req_o,
  output logic [ADDR_W-1:0] eng_addr_o,
  input  logic              eng_busy_i,
  input  logic              eng_done_i,
  input  logic              eng_nack_i,
  input  logic [7:0]        eng_data_i,
  output logic [FW-1:0]     svid_o,
  output logic [FW-1:0]     sid_o,
  output logic              cap_list_o,
  output logic              load_done_o
);
  logic                          ld_req;
  logic [ADDR_W-1:0]             ld_addr;
  logic                          retry_clr, retry_inc, retry_spent;
  logic [RCW-1:0]                retry_cnt;
  logic                          fld_wr, fld_clr;
  logic [FSEL_W-1:0]             fsel;
  logic [BSEL_W-1:0]             bsel;
  logic [NUM_FIELDS-1:0][FW-1:0] fld_vals;

  ldr_seq #(
    .ADDR_W(ADDR_W), .FIELD_BYTES(FIELD_BYTES), .CTRL_ADDR(CTRL_ADDR)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .eng_busy_i(eng_busy_i), .eng_done_i(eng_done_i), .eng_nack_i(eng_nack_i),
    .ctrl_en_i(eng_data_i[NUM_FIELDS-1:0]), .ctrl_cap_i(eng_data_i[CAP_BIT]),
    .retry_spent_i(retry_spent), .retry_clr_o(retry_clr), .retry_inc_o(retry_inc),
    .ld_req_o(ld_req), .ld_addr_o(ld_addr),
    .fld_wr_o(fld_wr), .fld_clr_o(fld_clr), .fsel_o(fsel), .bsel_o(bsel),
    .cap_list_o(cap_list_o), .load_done_o(load_done_o)
  );

  ldr_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk(clk), .rst_n(rst_n), .clr_i(retry_clr), .inc_i(retry_inc),
    .cnt_o(retry_cnt), .spent_o(retry_spent)
  );

  ldr_fields #(.FIELD_BYTES(FIELD_BYTES)) u_fields (
    .clk(clk), .rst_n(rst_n), .wr_i(fld_wr), .clr_i(fld_clr),
    .fsel_i(fsel), .bsel_i(bsel), .data_i(eng_data_i), .fields_o(fld_vals)
  );

  // host path is gated until the load sequence has finished
  assign eng_req_o  = ld_req | (host_req_i & load_done_o);
  assign eng_addr_o = ld_req ? ld_addr : host_addr_i;
  assign svid_o     = fld_vals[FLD_SVID];
  assign sid_o      = fld_vals[FLD_SID];
endmodule

// File: rtl/ee_cfg_loader_chk.sv
module ee_cfg_loader_chk #(
  parameter int ADDR_W    = 8,
  parameter int CTRL_ADDR = 0,
  parameter int MAX_RETRY = 4,
  parameter int RCW       = 3,
  parameter int FW        = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eng_req_o,
  input logic [ADDR_W-1:0] eng_addr_o,
  input logic              eng_busy_i,
  input logic              ld_req,
  input logic [RCW-1:0]    retry_cnt,
  input logic              cap_list_o,
  input logic              load_done_o,
  input logic [FW-1:0]     svid_o,
  input logic [FW-1:0]     sid_o
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen_q <= 1'b0;
    else if (eng_req_o) seen_q <= 1'b1;
  end

  a_r1_first_is_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req_o && !seen_q) |-> (eng_addr_o == ADDR_W'(CTRL_ADDR)));

  a_r6_single_cycle_req: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req |=> !ld_req);

  a_r6_engine_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req |-> !eng_busy_i);

  a_r7_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
    retry_cnt <= RCW'(MAX_RETRY));

  a_r2_cap_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_list_o |=> !cap_list_o);

  a_r9_host_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req_o && !load_done_o) |-> ld_req);

  a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    load_done_o |=> (load_done_o && $stable(svid_o) && $stable(sid_o) && $stable(cap_list_o)));
endmodule

bind ee_cfg_loader ee_cfg_loader_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .MAX_RETRY(MAX_RETRY), .RCW(RCW), .FW(FW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .eng_req_o(eng_req_o), .eng_addr_o(eng_addr_o),
  .eng_busy_i(eng_busy_i), .ld_req(ld_req), .retry_cnt(retry_cnt),
  .cap_list_o(cap_list_o), .load_done_o(load_done_o), .svid_o(svid_o), .sid_o(sid_o)
);

// File: tb/test_ee_cfg_loader.sv
`timescale 1ns/1ps
module test_ee_cfg_loader;
  logic        clk, rst_n;
  logic        host_req;
  logic [7:0]  host_addr;
  logic        eng_req;
  logic [7:0]  eng_addr;
  logic        eng_busy, eng_done, eng_nack;
  logic [7:0]  eng_data;
  logic [15:0] svid, sid;
  logic        cap_list, load_done;

  int checks = 0;
  int fails  = 0;

  // per-run EEPROM image and fault injection
  logic [7:0]  cfg_ctrl;
  logic [15:0] cfg_svid, cfg_sid;
  logic [7:0]  cfg_na;
  logic [3:0]  cfg_nc;

  // engine model state
  logic [1:0]  lat;
  logic [7:0]  cur;
  logic [3:0]  nack_left;
  int          reqs, leak, order_err;
  logic [7:0]  prev_addr, first_addr;
  logic        seen;

  ee_cfg_loader i_ee_cfg_loader (
    .clk(clk), .rst_n(rst_n), .host_req_i(host_req), .host_addr_i(host_addr),
    .eng_req_o(eng_req), .eng_addr_o(eng_addr), .eng_busy_i(eng_busy),
    .eng_done_i(eng_done), .eng_nack_i(eng_nack), .eng_data_i(eng_data),
    .svid_o(svid), .sid_o(sid), .cap_list_o(cap_list), .load_done_o(load_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] mem_rd(input logic [7:0] a);
    case (a)
      8'h00:   return cfg_ctrl;
      8'h01:   return cfg_svid[7:0];
      8'h02:   return cfg_svid[15:8];
      8'h03:   return cfg_sid[7:0];
      8'h04:   return cfg_sid[15:8];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_busy <= 1'b0; eng_done <= 1'b0; eng_nack <= 1'b0; eng_data <= 8'h00;
      lat <= 2'd0; cur <= 8'h00; nack_left <= cfg_nc;
      reqs <= 0; leak <= 0; order_err <= 0;
      prev_addr <= 8'h00; first_addr <= 8'hFF; seen <= 1'b0;
    end else begin
      eng_done <= 1'b0;
      if (eng_req && !eng_busy) begin
        eng_busy <= 1'b1; lat <= 2'd2; cur <= eng_addr;
        if (!load_done) begin
          reqs <= reqs + 1;
          if (eng_addr == 8'h55) leak <= leak + 1;
          if (seen && eng_addr < prev_addr) order_err <= order_err + 1;
          if (!seen) first_addr <= eng_addr;
          prev_addr <= eng_addr;
          seen <= 1'b1;
        end
      end else if (eng_busy) begin
        if (lat == 2'd0) begin
          eng_busy <= 1'b0;
          eng_done <= 1'b1;
          eng_data <= mem_rd(cur);
          eng_nack <= (cur == cfg_na) && (nack_left != 0);
          if (cur == cfg_na && nack_left != 0) nack_left <= nack_left - 4'd1;
        end else begin
          lat <= lat - 2'd1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // requirement model: expected outputs and read count
  task automatic model(output logic [15:0] e_svid, output logic [15:0] e_sid,
                       output logic e_cap, output int e_reqs);
    logic [7:0] en;
    int att[5];
    logic bad[5];
    for (int a = 0; a < 5; a++) begin
      bad[a] = (8'(a) == cfg_na) && (cfg_nc >= 5);
      att[a] = (8'(a) == cfg_na) ? ((cfg_nc >= 5) ? 5 : int'(cfg_nc) + 1) : 1;
    end
    e_reqs = att[0];
    en     = bad[0] ? 8'h00 : cfg_ctrl;
    e_cap  = !(en[2]);
    e_svid = 16'h0;
    e_sid  = 16'h0;
    if (en[0]) begin
      e_reqs += att[1];
      if (!bad[1]) begin
        e_reqs += att[2];
        if (!bad[2]) e_svid = cfg_svid;
      end
    end
    if (en[1]) begin
      e_reqs += att[3];
      if (!bad[3]) begin
        e_reqs += att[4];
        if (!bad[4]) e_sid = cfg_sid;
      end
    end
  endtask

  task automatic check_reset_state();
    chk("R1 svid in reset", 32'(svid), 32'h0);
    chk("R1 sid in reset", 32'(sid), 32'h0);
    chk("R1 cap in reset", 32'(cap_list), 32'h1);
    chk("R1 done in reset", 32'(load_done), 32'h0);
  endtask

  task automatic run_load(input string tag);
    logic [15:0] e_svid, e_sid;
    logic e_cap;
    int e_reqs, guard;
    model(e_svid, e_sid, e_cap, e_reqs);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_reset_state();
    rst_n    = 1'b1;
    host_req = 1'b1;   // held through the load: must never leak (R9)
    host_addr = 8'h55;
    guard = 0;
    while (!load_done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    host_req = 1'b0;
    if (!load_done) begin
      fails++; checks++;
      $display("FAIL R10 %s: load never completed, actual 0 expected 1", tag);
    end
    chk({"R3 svid ", tag}, 32'(svid), 32'(e_svid));
    chk({"R4 sid ", tag}, 32'(sid), 32'(e_sid));
    chk({"R2 cap ", tag}, 32'(cap_list), 32'(e_cap));
    chk({"R7 R8 read count ", tag}, 32'(reqs), 32'(e_reqs));
    chk({"R9 host leak ", tag}, 32'(leak), 32'h0);
    chk({"R6 address order ", tag}, 32'(order_err), 32'h0);
    chk({"R1 first address ", tag}, 32'(first_addr), 32'h0);
  endtask

  // {ctrl, svid, sid, nack_addr, nack_count}
  localparam logic [51:0] VEC [10] = '{
    {8'h03, 16'h1234, 16'hABCD, 8'hFF, 4'd0},  // both fields
    {8'h04, 16'h1111, 16'h2222, 8'hFF, 4'd0},  // cap cleared only
    {8'h01, 16'hBEEF, 16'hCAFE, 8'hFF, 4'd0},  // vendor only
    {8'h02, 16'hBEEF, 16'hCAFE, 8'hFF, 4'd0},  // subsystem only
    {8'hFB, 16'h5A5A, 16'hA5A5, 8'hFF, 4'd0},  // upper bits ignored (R5)
    {8'h07, 16'h0F0F, 16'hF0F0, 8'h02, 4'd4},  // last retry succeeds
    {8'h03, 16'h7777, 16'h8888, 8'h02, 4'd5},  // high byte exhausted
    {8'h03, 16'h7777, 16'h8888, 8'h01, 4'd9},  // low byte exhausted, high skipped
    {8'h07, 16'h3333, 16'h4444, 8'h00, 4'd5},  // control exhausted
    {8'h07, 16'h9999, 16'h6666, 8'h04, 4'd6}   // subsystem high exhausted
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] keep_svid;
    rst_n = 1'b0; host_req = 1'b0; host_addr = 8'h00;
    cfg_ctrl = 8'h00; cfg_svid = 16'h0; cfg_sid = 16'h0; cfg_na = 8'hFF; cfg_nc = 4'd0;

    for (int i = 0; i < 10; i++) begin
      {cfg_ctrl, cfg_svid, cfg_sid, cfg_na, cfg_nc} = VEC[i];
      run_load($sformatf("vec%0d", i));
    end

    // R9: host request passes through after loading, same cycle
    @(negedge clk);
    keep_svid = svid;
    host_addr = 8'h55;
    host_req  = 1'b1;
    #1;
    chk("R9 host request after done", 32'(eng_req), 32'h1);
    chk("R9 host address after done", 32'(eng_addr), 32'h55);
    @(negedge clk);
    host_req = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 done holds", 32'(load_done), 32'h1);
    chk("R10 svid stable", 32'(svid), 32'(keep_svid));

    // R1: reset in the middle of a load returns to the reset state and restarts
    cfg_ctrl = 8'h03; cfg_svid = 16'hDEAD; cfg_sid = 16'hF00D; cfg_na = 8'hFF; cfg_nc = 4'd0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (12) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_state();
    run_load("mid-load reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule